// File: doc/BRIEF.md
# Lane Permute Unit

The lane permute unit rearranges the lanes of two 128-bit SIMD operands into one 128-bit result. It sits beside the register file of a vector pipeline. The register file supplies the two operand values together with their register indices. The unit returns the permuted value and a write enable for the destination register. The whole path is combinational.

A 4-bit opcode selects one of eleven shuffles:

- packing alternate words;
- interleaving the low or high halves of the two operands at 8-, 16- or 32-bit lane width;
- replicating a halfword within each 64-bit half;
- two doubleword copies;
- a rotation of the lower three words.

Register index 0 is the hardwired zero register. A source with index 0 contributes all zeros whatever data arrives. A destination of index 0 drops the write.

Top module: `lane_permute`

## Requirements
- R1: Opcode 0 (pack words) gives result words, from word 0 upward: rt word 0, rt word 2, rs word 0, rs word 2.
- R2: Opcodes 1, 2 and 3 interleave the low 64 bits of both operands at lane widths 8, 16 and 32 bits. Result lane 2k takes rt lane k and lane 2k+1 takes rs lane k, filling from bit 0.
- R3: Opcodes 4, 5 and 6 perform the same interleave at widths 8, 16 and 32 bits, but draw on bits 127:64 of each operand. At word width the result words are rt w2, rs w2, rt w3, rs w3.
- R4: Opcode 7 copies bits 15:0 of rt into all four halfwords of the low result half. It copies bits 79:64 of rt into all four halfwords of the high half.
- R5: Opcode 8 places rt bits 63:0 in result bits 63:0 and rs bits 63:0 in result bits 127:64.
- R6: Opcode 9 places rs bits 127:64 in result bits 63:0 and rt bits 127:64 in result bits 127:64.
- R7: Opcode 10 gives result words rt w1, rt w2, rt w0, rt w3. Word 3 stays where it was.
- R8: A destination index of 0 holds the write enable low for every opcode.
- R9: A source index of 0 makes that operand read as all zeros, whatever its data input carries.
- R10: Opcodes 11 to 15 are unassigned. They hold the write enable low and drive a zero result.
- R11: An assigned opcode with a nonzero destination index raises the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Shuffle opcode |
| rsIdx | input | 5 | Register index of the first operand |
| rtIdx | input | 5 | Register index of the second operand |
| rdIdx | input | 5 | Destination register index |
| rsData | input | 128 | First operand value |
| rtData | input | 128 | Second operand value |
| result | output | 128 | Permuted value |
| writeEn | output | 1 | Destination write enable |

## Verification
Each operand byte carries a distinct value, so a lane taken from the wrong operand, the wrong half or the wrong position shows up as a mismatch. If rt and rs were swapped in an interleave pair, every even lane would change places with an odd lane. If the high-half interleaves still read the low half, they would repeat the low-half results. A rotation that moved word 3 would corrupt the top 32 bits. The bench also drives index 0 on each source with nonzero data and sets the destination to 0. A design that ignored the zero register would leak that data into the result or raise a spurious write. Unassigned opcodes are swept to catch a decoder that aliases them onto real shuffles.

// File: rtl/lane_permute_pkg.sv
package lane_permute_pkg;

  localparam int unsigned OP_W = 4;
  localparam int unsigned IDX_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PACK_W   = 4'd0,
    OP_ILV_LO_B = 4'd1,
    OP_ILV_LO_H = 4'd2,
    OP_ILV_LO_W = 4'd3,
    OP_ILV_HI_B = 4'd4,
    OP_ILV_HI_H = 4'd5,
    OP_ILV_HI_W = 4'd6,
    OP_DUP_H    = 4'd7,
    OP_CPY_LO_D = 4'd8,
    OP_CPY_HI_D = 4'd9,
    OP_ROT3_W   = 4'd10
  } permOp_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd10;

  // lane width codes for the interleave network
  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2
  } laneW_e;

  typedef struct packed {
    logic   selPack;
    logic   selIlv;
    logic   ilvUpper;
    laneW_e ilvWidth;
    logic   selDup;
    logic   selCpyLo;
    logic   selCpyHi;
    logic   selRot;
    logic   zeroRs;
    logic   zeroRt;
  } permStrb_t;

endpackage

// File: rtl/lane_permute_ctrl.sv
module lane_permute_ctrl
  import lane_permute_pkg::*;
(
  input  logic [OP_W-1:0]  opSel,
  input  logic [IDX_W-1:0] rsIdx,
  input  logic [IDX_W-1:0] rtIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output permStrb_t        strb,
  output logic             writeEn
);

  logic opValid;

  always_comb begin
    strb          = '0;
    strb.ilvWidth = LW_BYTE;
    strb.zeroRs   = (rsIdx == '0);
    strb.zeroRt   = (rtIdx == '0);
    opValid       = 1'b1;
    case (opSel)
      OP_PACK_W:   strb.selPack = 1'b1;
      OP_ILV_LO_B: begin strb.selIlv = 1'b1; strb.ilvWidth = LW_BYTE; end
      OP_ILV_LO_H: begin strb.selIlv = 1'b1; strb.ilvWidth = LW_HALF; end
      OP_ILV_LO_W: begin strb.selIlv = 1'b1; strb.ilvWidth = LW_WORD; end
      OP_ILV_HI_B: begin strb.selIlv = 1'b1; strb.ilvUpper = 1'b1; strb.ilvWidth = LW_BYTE; end
      OP_ILV_HI_H: begin strb.selIlv = 1'b1; strb.ilvUpper = 1'b1; strb.ilvWidth = LW_HALF; end
      OP_ILV_HI_W: begin strb.selIlv = 1'b1; strb.ilvUpper = 1'b1; strb.ilvWidth = LW_WORD; end
      OP_DUP_H:    strb.selDup   = 1'b1;
      OP_CPY_LO_D: strb.selCpyLo = 1'b1;
      OP_CPY_HI_D: strb.selCpyHi = 1'b1;
      OP_ROT3_W:   strb.selRot   = 1'b1;
      default:     opValid       = 1'b0;
    endcase
  end

  // R8 / R11: write only for assigned opcodes into a real register
  assign writeEn = opValid && (rdIdx != '0);

endmodule

// File: rtl/lane_permute_dp.sv
module lane_permute_dp
  import lane_permute_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  permStrb_t         strb,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HW_W   = 16;
  localparam int unsigned N_LW   = 3;

  logic [DATA_W-1:0] opA, opB;
  logic [DATA_W-1:0] packRes, dupRes, cpyLoRes, cpyHiRes, rotRes;
  logic [DATA_W-1:0] ilvRes [N_LW][2];
  logic [DATA_W-1:0] ilvSel;

  // R9: zero register reads as zero
  assign opA = strb.zeroRs ? '0 : rsData;
  assign opB = strb.zeroRt ? '0 : rtData;

  // R1: alternate words, rt first
  assign packRes = {opA[2*WORD_W +: WORD_W], opA[0 +: WORD_W],
                    opB[2*WORD_W +: WORD_W], opB[0 +: WORD_W]};

  // R2 / R3: interleave network, one instance per lane width and half
  for (genvar g = 0; g < N_LW; g++) begin : g_width
    localparam int unsigned LW    = 8 << g;
    localparam int unsigned NLANE = HALF_W / LW;
    for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign ilvRes[g][h][2*k*LW +: LW]      = opB[h*HALF_W + k*LW +: LW];
        assign ilvRes[g][h][(2*k+1)*LW +: LW]  = opA[h*HALF_W + k*LW +: LW];
      end
    end
  end

  always_comb begin
    case (strb.ilvWidth)
      LW_HALF: ilvSel = strb.ilvUpper ? ilvRes[1][1] : ilvRes[1][0];
      LW_WORD: ilvSel = strb.ilvUpper ? ilvRes[2][1] : ilvRes[2][0];
      default: ilvSel = strb.ilvUpper ? ilvRes[0][1] : ilvRes[0][0];
    endcase
  end

  // R4: replicate base halfword of each half
  for (genvar h = 0; h < 2; h++) begin : g_dupHalf
    for (genvar q = 0; q < HALF_W / HW_W; q++) begin : g_dupLane
      assign dupRes[h*HALF_W + q*HW_W +: HW_W] = opB[h*HALF_W +: HW_W];
    end
  end

  // R5 / R6: doubleword copies
  assign cpyLoRes = {opA[0 +: HALF_W], opB[0 +: HALF_W]};
  assign cpyHiRes = {opB[HALF_W +: HALF_W], opA[HALF_W +: HALF_W]};

  // R7: rotate lower three words, top word stays
  assign rotRes = {opB[3*WORD_W +: WORD_W], opB[0 +: WORD_W],
                   opB[2*WORD_W +: WORD_W], opB[WORD_W +: WORD_W]};

  // R10: one-hot select, zero when nothing selected
  always_comb begin
    result = '0;
    if (strb.selPack)  result = packRes;
    if (strb.selIlv)   result = ilvSel;
    if (strb.selDup)   result = dupRes;
    if (strb.selCpyLo) result = cpyLoRes;
    if (strb.selCpyHi) result = cpyHiRes;
    if (strb.selRot)   result = rotRes;
  end

endmodule

// File: rtl/lane_permute.sv
module lane_permute
  import lane_permute_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic [OP_W-1:0]   opSel,
  input  logic [IDX_W-1:0]  rsIdx,
  input  logic [IDX_W-1:0]  rtIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] rsData,
  input  logic [DATA_W-1:0] rtData,
  output logic [DATA_W-1:0] result,
  output logic              writeEn
);

  permStrb_t strb;

  lane_permute_ctrl u_ctrl (
    .opSel   (opSel),
    .rsIdx   (rsIdx),
    .rtIdx   (rtIdx),
    .rdIdx   (rdIdx),
    .strb    (strb),
    .writeEn (writeEn)
  );

  lane_permute_dp #(.DATA_W(DATA_W)) u_dp (
    .strb   (strb),
    .rsData (rsData),
    .rtData (rtData),
    .result (result)
  );

endmodule

// File: rtl/lane_permute_chk.sv
module lane_permute_chk
  import lane_permute_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input logic [OP_W-1:0]   opSel,
  input logic [IDX_W-1:0]  rsIdx,
  input logic [IDX_W-1:0]  rtIdx,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [DATA_W-1:0] rsData,
  input logic [DATA_W-1:0] rtData,
  input logic [DATA_W-1:0] result,
  input logic              writeEn
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] effRs, effRt;
  assign effRs = (rsIdx == '0) ? '0 : rsData;
  assign effRt = (rtIdx == '0) ? '0 : rtData;

  always_comb begin
    if (rdIdx == '0)
      a_r8_no_write_rd0: assert (!writeEn) else $error("R8 write to index 0");
    if (opSel > OP_LAST)
      a_r10_unassigned: assert (!writeEn && result == '0) else $error("R10 unassigned op active");
    if (opSel <= OP_LAST && rdIdx != '0)
      a_r11_write_on: assert (writeEn) else $error("R11 write enable missing");
    if (opSel == OP_ROT3_W)
      a_r7_top_word_kept: assert (result[DATA_W-1 -: 32] == effRt[DATA_W-1 -: 32])
        else $error("R7 top word moved");
    if (opSel == OP_CPY_LO_D)
      a_r5_low_copy: assert (result == {effRs[0 +: HALF_W], effRt[0 +: HALF_W]})
        else $error("R5 copy mismatch");
    if (opSel == OP_DUP_H && rtIdx == '0)
      a_r9_zero_source: assert (result == '0) else $error("R9 zero source leaked");
  end

endmodule

bind lane_permute lane_permute_chk #(.DATA_W(DATA_W)) u_chk (
  .opSel   (opSel),
  .rsIdx   (rsIdx),
  .rtIdx   (rtIdx),
  .rdIdx   (rdIdx),
  .rsData  (rsData),
  .rtData  (rtData),
  .result  (result),
  .writeEn (writeEn)
);

// File: tb/tb_lane_permute.sv
`timescale 1ns/1ps
module tb_lane_permute;

  logic         clk = 1'b0;
  logic [3:0]   opSel;
  logic [4:0]   rsIdx, rtIdx, rdIdx;
  logic [127:0] rsData, rtData;
  logic [127:0] result;
  logic         writeEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_permute dut (
    .opSel(opSel), .rsIdx(rsIdx), .rtIdx(rtIdx), .rdIdx(rdIdx),
    .rsData(rsData), .rtData(rtData), .result(result), .writeEn(writeEn)
  );

  function automatic logic [31:0] wd(input logic [127:0] v, input int n);
    logic [31:0] r;
    for (int j = 0; j < 32; j++) r[j] = v[n*32 + j];
    return r;
  endfunction

  function automatic logic [127:0] ilvModel(input logic [127:0] a, input logic [127:0] b,
                                            input int w, input bit up);
    logic [127:0] r;
    int base;
    base = up ? 64 : 0;
    for (int k = 0; k < 64 / w; k++)
      for (int j = 0; j < w; j++) begin
        r[(2*k)*w + j]   = b[base + k*w + j];
        r[(2*k+1)*w + j] = a[base + k*w + j];
      end
    return r;
  endfunction

  function automatic logic [127:0] model(input logic [3:0] op, input logic [127:0] a,
                                         input logic [127:0] b);
    case (op)
      4'd0:  return {wd(a,2), wd(a,0), wd(b,2), wd(b,0)};
      4'd1:  return ilvModel(a, b, 8, 0);
      4'd2:  return ilvModel(a, b, 16, 0);
      4'd3:  return ilvModel(a, b, 32, 0);
      4'd4:  return ilvModel(a, b, 8, 1);
      4'd5:  return ilvModel(a, b, 16, 1);
      4'd6:  return ilvModel(a, b, 32, 1);
      4'd7:  return {{4{b[79:64]}}, {4{b[15:0]}}};
      4'd8:  return {a[63:0], b[63:0]};
      4'd9:  return {b[127:64], a[127:64]};
      4'd10: return {wd(b,3), wd(b,0), wd(b,2), wd(b,1)};
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2, 4'd3: return "R2";
      4'd4, 4'd5, 4'd6: return "R3";
      4'd7: return "R4";
      4'd8: return "R5";
      4'd9: return "R6";
      4'd10: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 2 ns later
  task automatic apply(input logic [3:0] op, input logic [4:0] s, input logic [4:0] t,
                       input logic [4:0] d, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] ea, eb;
    bit expEn;
    @(negedge clk);
    opSel = op; rsIdx = s; rtIdx = t; rdIdx = d; rsData = a; rtData = b;
    #2;
    ea = (s == 0) ? '0 : a;
    eb = (t == 0) ? '0 : b;
    chk(reqOf(op), result, model(op, ea, eb));
    expEn = (op <= 4'd10) && (d != 0);
    if (d == 0)          chk("R8",  {127'd0, writeEn}, {127'd0, 1'b0});
    else if (op > 4'd10) chk("R10", {127'd0, writeEn}, {127'd0, 1'b0});
    else                 chk("R11", {127'd0, writeEn}, {127'd0, expEn});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] pa, pb;
    void'($urandom(32'h1d2c3b4a));
    opSel = 4'd15; rsIdx = 0; rtIdx = 0; rdIdx = 0; rsData = '0; rtData = '0;
    #2;
    // idle state: unassigned op, zero indices
    chk("R10", result, '0);
    chk("R8", {127'd0, writeEn}, 128'd0);

    for (int i = 0; i < 16; i++) begin
      pa[i*8 +: 8] = 8'hA0 + 8'(i);
      pb[i*8 +: 8] = 8'h50 + 8'(i);
    end
    // directed: every opcode with distinct byte patterns (R1..R7, R10, R11)
    for (int op = 0; op < 16; op++) apply(4'(op), 5'd3, 5'd4, 5'd7, pa, pb);
    // explicit word-level expectations
    apply(4'd6, 5'd1, 5'd2, 5'd3, pa, pb);
    chk("R3", result, {wd(pa,3), wd(pb,3), wd(pa,2), wd(pb,2)});
    apply(4'd10, 5'd1, 5'd2, 5'd3, pa, pb);
    chk("R7", result, {wd(pb,3), wd(pb,0), wd(pb,2), wd(pb,1)});
    // R9: zero-register sources with nonzero data
    for (int op = 0; op < 11; op++) begin
      apply(4'(op), 5'd0, 5'd9, 5'd1, pa, pb);
      apply(4'(op), 5'd9, 5'd0, 5'd1, pa, pb);
    end
    // R8: destination zero on all ops
    for (int op = 0; op < 16; op++) apply(4'(op), 5'd5, 5'd6, 5'd0, pa, pb);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      apply(4'($urandom % 16), 5'($urandom % 4), 5'($urandom % 4),
            5'($urandom % 4), ra, rb);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule